// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block holds the tags, valid bits and replacement state of a 4-way set-associative, write-through data cache. The data array lives elsewhere. A client presents a byte address with a one-cycle strobe. One clock later the directory answers with hit or miss and a way number. On a hit, the way number is the way that holds the line. On a miss, it is the way just allocated for the refill.

The address has three fields: a byte-in-line field, a set index and a tag. The set index comes either straight from the address bits or from an XOR fold of higher bits into those bits. An elaboration parameter picks one of the two. The fold spreads power-of-two strides over many sets, where they would otherwise pile into one set and thrash it.

Each set keeps an exact least-recently-used order as an age rank per way. A flush pulse sweeps the sets one per cycle. Two saturating counters record accepted lookups and misses. Because the cache is write-through, there is no dirty state and eviction needs no write-back.

Top module: `cache_tag_dir`

## Requirements
- R1: Address bits [5:0] pick a byte within a 64-byte line and never affect the outcome. Any address in a line that is already resident hits. In plain mode the set is bits [11:6] and the tag is every bit from 12 upward.
- R2: A request presented while the directory is not sweeping gives `rsp_valid_o` high exactly one cycle later. In any other cycle `rsp_valid_o` is low.
- R3: A hit reports the way that holds the line, and that way becomes most recently used. Two identical back-to-back lookups report the same way.
- R4: A miss allocates the way whose age rank is 3 (least recently used), reports it on `rsp_way_o`, and makes it most recently used. After reset or a flush, a set fills in way order 3, 2, 1, 0.
- R5: In plain mode, five lines spaced 16 KB apart share one set. Cycling through them misses on every access.
- R6: In hashed mode the set index is bits [11:6] XOR bits [17:12], and the tag is still every bit from 12 upward. Lines with equal fold values conflict, and lines that are 16 KB apart spread over separate sets.
- R7: A flush pulse while idle raises `flush_busy_o` for 64 cycles, one per set. Afterwards every line misses. Requests made while busy get no response and do not change the counters.
- R8: Reset invalidates every line, clears both counters and the busy flag, and restores the 3, 2, 1, 0 fill order.
- R9: The access counter adds one per accepted request and the miss counter adds one per miss. Both are updated in the response cycle and both stop at 2^CNT_W-1.
- R10: `cnt_clr_i` zeroes both counters on the next edge. It takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup request strobe |
| lk_addr_i | input | ADDR_W | Byte address of the lookup |
| flush_i | input | 1 | Starts an invalidate sweep when idle |
| cnt_clr_i | input | 1 | Clears both event counters |
| flush_busy_o | output | 1 | Sweep in progress; requests ignored |
| rsp_valid_o | output | 1 | Response present this cycle |
| rsp_hit_o | output | 1 | 1 = hit, 0 = miss |
| rsp_way_o | output | $clog2(WAYS) | Hit way, or allocated way on a miss |
| access_cnt_o | output | CNT_W | Saturating count of accepted lookups |
| miss_cnt_o | output | CNT_W | Saturating count of misses |

## Verification
The bench builds two instances and drives both with the same stimulus. The first uses the plain index and 5-bit counters, so counter saturation at 31 is reached within a few dozen lookups. The second uses the XOR-folded index and 32-bit counters. Because both see the same stride patterns, a 16 KB stride thrashes the plain instance and all hits in the hashed one on its second pass. A pattern built to collide under the fold gives the reverse result, which pins down the exact hash bits.

// File: rtl/cache_dir_pkg.sv
package cache_dir_pkg;

    // How the set index is formed from the line address.
    typedef enum logic {
        IDX_PLAIN = 1'b0,
        IDX_XOR   = 1'b1
    } idx_mode_e;

endpackage

// File: rtl/cache_index_map.sv
module cache_index_map
    import cache_dir_pkg::*;
#(
    parameter int        ADDR_W = 32,
    parameter int        OFF_W  = 6,
    parameter int        IDX_W  = 6,
    parameter idx_mode_e MODE   = IDX_PLAIN
) (
    input  logic [ADDR_W-1:OFF_W]              line_i,
    output logic [IDX_W-1:0]                   idx_o,
    output logic [ADDR_W-OFF_W-IDX_W-1:0]      tag_o
);

    localparam int IDX_LO = OFF_W;
    localparam int IDX_HI = OFF_W + IDX_W - 1;

    // The tag always keeps every bit above the raw index, so a line stays unique in either mode.
    assign tag_o = line_i[ADDR_W-1:IDX_HI+1];

    generate
        if (MODE == IDX_XOR) begin : g_xor
            assign idx_o = line_i[IDX_HI:IDX_LO] ^ line_i[IDX_HI+IDX_W:IDX_HI+1];
        end else begin : g_plain
            assign idx_o = line_i[IDX_HI:IDX_LO];
        end
    endgenerate

endmodule

// File: rtl/cache_way_match.sv
module cache_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic [WAYS-1:0]                valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0]     tags_i,
    input  logic [TAG_W-1:0]               tag_i,
    output logic                           hit_o,
    output logic [$clog2(WAYS)-1:0]        way_o
);

    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0] match;

    always_comb begin
        way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            match[w] = valid_i[w] && (tags_i[w] == tag_i);
            if (match[w]) way_o = WAY_W'(w);
        end
        hit_o = |match;
    end

    // A line is allocated only on a miss, so at most one way of a set may hold it.
    p_single_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(match));

endmodule

// File: rtl/cache_age_lru.sv
module cache_age_lru #(
    parameter int WAYS = 4
) (
    input  logic                                   clk_i,
    input  logic                                   rst_ni,
    input  logic                                   en_i,
    input  logic [WAYS-1:0][$clog2(WAYS)-1:0]      age_i,
    input  logic [$clog2(WAYS)-1:0]                touch_i,
    output logic [$clog2(WAYS)-1:0]                victim_o,
    output logic [WAYS-1:0][$clog2(WAYS)-1:0]      age_o
);

    localparam int AGE_W = $clog2(WAYS);
    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

    logic [WAYS-1:0] oldest_mark;

    always_comb begin
        victim_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_i[w] == OLDEST) victim_o = AGE_W'(w);
        end
    end

    // The touched way drops to rank 0; every way that was younger moves back one place.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            if (AGE_W'(w) == touch_i) begin
                age_o[w] = '0;
            end else if (age_i[w] < age_i[touch_i]) begin
                age_o[w] = age_i[w] + AGE_W'(1);
            end else begin
                age_o[w] = age_i[w];
            end
            oldest_mark[w] = (age_o[w] == OLDEST);
        end
    end

    // The updated ranking must still name exactly one least recent way.
    p_one_oldest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |-> ($countones(oldest_mark) == 1));

endmodule

// File: rtl/cache_event_counter.sv
module cache_event_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != TOP)) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    p_cnt_hold_top_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == TOP && !clr_i) |=> (cnt_q == TOP));

    p_cnt_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
    import cache_dir_pkg::*;
#(
    parameter int        ADDR_W     = 32,
    parameter int        LINE_BYTES = 64,
    parameter int        SETS       = 64,
    parameter int        WAYS       = 4,
    parameter int        CNT_W      = 32,
    parameter idx_mode_e IDX_MODE   = IDX_PLAIN
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      lk_valid_i,
    input  logic [ADDR_W-1:0]         lk_addr_i,
    input  logic                      flush_i,
    input  logic                      cnt_clr_i,
    output logic                      flush_busy_o,
    output logic                      rsp_valid_o,
    output logic                      rsp_hit_o,
    output logic [$clog2(WAYS)-1:0]   rsp_way_o,
    output logic [CNT_W-1:0]          access_cnt_o,
    output logic [CNT_W-1:0]          miss_cnt_o
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             valid;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][WAY_W-1:0]  age;
        logic                                  busy;
        logic [IDX_W-1:0]                      ptr;
        logic                                  rsp_valid;
        logic                                  rsp_hit;
        logic [WAY_W-1:0]                      rsp_way;
    } dir_state_t;

    dir_state_t st_d, st_q;

    function automatic dir_state_t initial_state();
        dir_state_t s;
        s = '0;
        for (int i = 0; i < SETS; i++) begin
            for (int w = 0; w < WAYS; w++) begin
                s.age[i][w] = WAY_W'(w);
            end
        end
        return s;
    endfunction

    logic [IDX_W-1:0]                  idx;
    logic [TAG_W-1:0]                  tag;
    logic                              hit;
    logic [WAY_W-1:0]                  hit_way;
    logic [WAY_W-1:0]                  victim;
    logic [WAY_W-1:0]                  touch;
    logic [WAYS-1:0][WAY_W-1:0]        age_next;
    logic                              accept;
    logic                              offset_unused;

    assign offset_unused = ^lk_addr_i[OFF_W-1:0];
    assign accept        = lk_valid_i && !st_q.busy;
    assign touch         = hit ? hit_way : victim;

    cache_index_map #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .MODE   (IDX_MODE)
    ) u_index (
        .line_i (lk_addr_i[ADDR_W-1:OFF_W]),
        .idx_o  (idx),
        .tag_o  (tag)
    );

    cache_way_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_match (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .valid_i (st_q.valid[idx]),
        .tags_i  (st_q.tag[idx]),
        .tag_i   (tag),
        .hit_o   (hit),
        .way_o   (hit_way)
    );

    cache_age_lru #(
        .WAYS (WAYS)
    ) u_lru (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (accept),
        .age_i    (st_q.age[idx]),
        .touch_i  (touch),
        .victim_o (victim),
        .age_o    (age_next)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_hit   = 1'b0;
        st_d.rsp_way   = '0;
        if (st_q.busy) begin
            st_d.valid[st_q.ptr] = '0;
            for (int w = 0; w < WAYS; w++) begin
                st_d.age[st_q.ptr][w] = WAY_W'(w);
            end
            st_d.ptr = st_q.ptr + IDX_W'(1);
            if (st_q.ptr == IDX_W'(SETS - 1)) st_d.busy = 1'b0;
        end else begin
            if (accept) begin
                st_d.rsp_valid = 1'b1;
                st_d.rsp_hit   = hit;
                st_d.rsp_way   = touch;
                st_d.age[idx]  = age_next;
                if (!hit) begin
                    st_d.valid[idx][victim] = 1'b1;
                    st_d.tag[idx][victim]   = tag;
                end
            end
            if (flush_i) begin
                st_d.busy = 1'b1;
                st_d.ptr  = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= initial_state();
        else         st_q <= st_d;
    end

    cache_event_counter #(.CNT_W(CNT_W)) u_acc_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cnt_clr_i),
        .inc_i  (accept),
        .cnt_o  (access_cnt_o)
    );

    cache_event_counter #(.CNT_W(CNT_W)) u_miss_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cnt_clr_i),
        .inc_i  (accept && !hit),
        .cnt_o  (miss_cnt_o)
    );

    assign flush_busy_o = st_q.busy;
    assign rsp_valid_o  = st_q.rsp_valid;
    assign rsp_hit_o    = st_q.rsp_hit;
    assign rsp_way_o    = st_q.rsp_way;

    p_rsp_after_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lk_valid_i && !flush_busy_o) |=> rsp_valid_o);

    p_no_rsp_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(lk_valid_i && !flush_busy_o) |=> !rsp_valid_o);

    p_repeat_hits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && $past(accept) &&
         (lk_addr_i[ADDR_W-1:OFF_W] == $past(lk_addr_i[ADDR_W-1:OFF_W])))
        |=> (rsp_hit_o && (rsp_way_o == $past(rsp_way_o))));

    p_flush_starts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flush_i && !flush_busy_o) |=> flush_busy_o);

    p_flush_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && st_q.ptr == IDX_W'(SETS - 1)) |=> !flush_busy_o);

    p_miss_within_acc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        miss_cnt_o <= access_cnt_o);

endmodule

// File: tb/cache_tag_dir_tb.sv
`timescale 1ns/1ps
module cache_tag_dir_tb_top;
    import cache_dir_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        flush = 1'b0;
    logic        cnt_clr = 1'b0;

    logic        busy_i, rv_i, hit_i;
    logic [1:0]  way_i;
    logic [4:0]  acc_i, miss_i;
    logic        busy_h, rv_h, hit_h;
    logic [1:0]  way_h;
    logic [31:0] acc_h, miss_h;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    cache_tag_dir #(.CNT_W(5), .IDX_MODE(IDX_PLAIN)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .lk_valid_i(req_valid), .lk_addr_i(req_addr),
        .flush_i(flush), .cnt_clr_i(cnt_clr), .flush_busy_o(busy_i),
        .rsp_valid_o(rv_i), .rsp_hit_o(hit_i), .rsp_way_o(way_i),
        .access_cnt_o(acc_i), .miss_cnt_o(miss_i));

    cache_tag_dir #(.IDX_MODE(IDX_XOR)) dut_h (
        .clk_i(clk), .rst_ni(rst_n), .lk_valid_i(req_valid), .lk_addr_i(req_addr),
        .flush_i(flush), .cnt_clr_i(cnt_clr), .flush_busy_o(busy_h),
        .rsp_valid_o(rv_h), .rsp_hit_o(hit_h), .rsp_way_o(way_h),
        .access_cnt_o(acc_h), .miss_cnt_o(miss_h));

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One request; returns at the falling edge after the response edge.
    task automatic look(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "rsp_valid plain", 32'(rv_i), 1);
        chk("R2", "rsp_valid hashed", 32'(rv_h), 1);
    endtask

    task automatic expect_i(input string req, input logic h, input logic [1:0] w);
        chk(req, "hit plain", 32'(hit_i), 32'(h));
        chk(req, "way plain", 32'(way_i), 32'(w));
    endtask

    task automatic expect_h(input string req, input logic h, input logic [1:0] w);
        chk(req, "hit hashed", 32'(hit_h), 32'(h));
        chk(req, "way hashed", 32'(way_h), 32'(w));
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        while (busy_i) @(negedge clk);
    endtask

    task automatic clear_counts();
        @(negedge clk); cnt_clr = 1'b1;
        @(negedge clk); cnt_clr = 1'b0;
        chk("R10", "acc plain cleared", 32'(acc_i), 0);
        chk("R10", "miss hashed cleared", miss_h, 0);
    endtask

    task automatic t_reset_state();
        chk("R8", "busy after reset", 32'(busy_i), 0);
        chk("R8", "rsp_valid after reset", 32'(rv_i), 0);
        chk("R8", "acc after reset", 32'(acc_i), 0);
        chk("R8", "miss after reset", miss_h, 0);
    endtask

    task automatic t_offset();
        look(32'h100);   expect_i("R4", 0, 3); expect_h("R4", 0, 3);
        look(32'h13F);   expect_i("R1", 1, 3); expect_h("R1", 1, 3);
        // plain: same set 4, LRU is way 2; hashed: folds to fresh set 5
        look(32'h1100);  expect_i("R1", 0, 2); expect_h("R6", 0, 3);
    endtask

    task automatic t_lru();
        do_flush();
        look(32'h0000);  expect_i("R4", 0, 3);
        look(32'h4000);  expect_i("R4", 0, 2);
        look(32'h8000);  expect_i("R4", 0, 1);
        look(32'hC000);  expect_i("R4", 0, 0);
        look(32'h0000);  expect_i("R3", 1, 3);
        look(32'h10000); expect_i("R4", 0, 2);
        look(32'h0000);  expect_i("R3", 1, 3);
        look(32'h4000);  expect_i("R4", 0, 1);
    endtask

    task automatic t_stride();
        do_flush();
        clear_counts();
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 5; k++) begin
                look(32'(k) * 32'h4000);
                chk("R5", "plain stride misses", 32'(hit_i), 0);
                chk("R6", "hashed stride", 32'(hit_h), 32'(p));
            end
        end
        chk("R9", "acc plain", 32'(acc_i), 10);
        chk("R9", "miss plain", 32'(miss_i), 10);
        chk("R9", "acc hashed", acc_h, 10);
        chk("R9", "miss hashed", miss_h, 5);
    endtask

    task automatic t_hash_conflict();
        do_flush();
        for (int p = 0; p < 2; p++) begin
            for (int t = 0; t < 5; t++) begin
                look(32'(t) * 32'h1040);
                chk("R1", "plain spread", 32'(hit_i), 32'(p));
                chk("R6", "hashed fold conflict", 32'(hit_h), 0);
            end
        end
    endtask

    task automatic t_flush();
        int n;
        logic [4:0] a0;
        do_flush();
        look(32'h200); expect_i("R4", 0, 3); expect_h("R4", 0, 3);
        look(32'h200); expect_i("R3", 1, 3); expect_h("R3", 1, 3);
        a0 = acc_i;
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        chk("R7", "busy raised", 32'(busy_i), 1);
        req_valid = 1'b1; req_addr = 32'h200;
        @(negedge clk); req_valid = 1'b0;
        chk("R7", "no rsp while busy plain", 32'(rv_i), 0);
        chk("R7", "no rsp while busy hashed", 32'(rv_h), 0);
        chk("R7", "acc unchanged while busy", 32'(acc_i), 32'(a0));
        n = 1;
        while (busy_i) begin n++; @(negedge clk); end
        chk("R7", "sweep length", 32'(n), 64);
        look(32'h200); expect_i("R7", 0, 3); expect_h("R7", 0, 3);
    endtask

    task automatic t_counters();
        clear_counts();
        for (int i = 1; i <= 35; i++) look(32'(i) * 32'h1000);
        chk("R9", "acc plain saturates", 32'(acc_i), 31);
        chk("R9", "miss plain saturates", 32'(miss_i), 31);
        chk("R9", "acc hashed", acc_h, 35);
        chk("R9", "miss hashed", miss_h, 35);
        @(negedge clk); cnt_clr = 1'b1; req_valid = 1'b1; req_addr = 32'h7000;
        @(negedge clk); cnt_clr = 1'b0; req_valid = 1'b0;
        chk("R10", "clear beats increment acc", 32'(acc_i), 0);
        chk("R10", "clear beats increment miss", miss_h, 0);
        look(32'h200); expect_i("R3", 1, 3);
        chk("R9", "acc after clear", 32'(acc_i), 1);
        chk("R9", "miss after clear", miss_h, 0);
    endtask

    task automatic t_reset_mid();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        look(32'h200); expect_i("R8", 0, 3); expect_h("R8", 0, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_offset();
        t_lru();
        t_stride();
        t_hash_conflict();
        t_flush();
        t_counters();
        t_reset_mid();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule